// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar as packed BCD digits. It holds seconds, minutes, hours, day of month, month, two-digit year and a day-of-week counter. A 32.768 kHz oscillator reaches it as a one-cycle enable on the system clock. An internal divider turns that enable into a one-second tick. The seconds counter then ripples carries through the rest of the chain. Month lengths and leap years are worked out from the stored digits.

A host reaches every digit through a 4-bit digit select, with separate read and write ports. Several controls act on the counting:

- Hold defers the one-second tick.
- Stop freezes the divider above its first two stages.
- Sub-second clear resets the divider.
- Test mode clocks the seconds from an early divider stage.
- The hour format input picks 12-hour or 24-hour counting.
- A pulse on the adjust input rounds the seconds to the nearest minute, after a short timed window.

A busy output tells the host when a deferred tick or an adjustment is still outstanding.

Top module: `rtc_bcd_clock`

## Requirements
- R1: Seconds and minutes count 00 to 59 and then wrap with a carry. In 24-hour mode (mode24_i=1) hours count 00 to 23, and the wrap carries into the day.
- R2: In 12-hour mode hours run 12, 01 … 11. Bit 2 of the tens-of-hours digit (select 7) is the PM flag, 1 meaning PM. The flag toggles on 11→12, and the day advances only when 11 PM becomes 12 AM.
- R3: In 24-hour mode the PM flag cannot be written and always reads 0.
- R4: The day wraps to 01 after the last day of the month. That day is 30 for months 4, 6, 9 and 11, and 31 for the others. February has 29 days when the year number is divisible by 4 (year 00 included) and 28 days otherwise.
- R5: An out-of-range day keeps its written value until the next day carry. At that carry it becomes day 01 of the following month.
- R6: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R7: The day-of-week counter (select 6) advances on every day carry and wraps from 6 to 0.
- R8: While hold_i=1 the time does not change. A tick that arrives during hold raises busy_o and is applied exactly once in the cycle after hold_i falls.
- R9: A pulse on adj_i raises busy_o for ADJ_OSC oscillator enables. When that window closes, seconds 00–29 become 00 with the minutes unchanged. Seconds 30–59 become 00 and the minutes advance by one.
- R10: With test_i=0, stop_i=1 blocks the one-second tick. clr_sub_i=1 clears the divider, so the first tick after release comes after a full 2^DIV_BITS enables.
- R11: With test_i=1 the seconds advance once every 2^TEST_TAP enables, and stop_i and clr_sub_i have no effect.
- R12: The digit selects are 0 y10, 1 y1, 2 mo10, 3 mo1, 4 d10, 5 d1, 6 weekday, 7 PM/h10, 8 h1, 9 mi10, 10 mi1, 11 s10, 12 s1. Bits a digit does not implement are dropped on write and read as 0. These are: mo10 above bit 0, d10 above bit 1, h10 bit 3, and bit 3 of s10, mi10 and weekday.
- R13: After reset the time reads 00:00:00, the date reads year 00, month 01, day 01, the weekday reads 0, and busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | One-cycle enable per oscillator period |
| hold_i | input | 1 | Defer the one-second tick |
| stop_i | input | 1 | Freeze the divider above the prescaler |
| clr_sub_i | input | 1 | Hold the sub-second divider cleared |
| test_i | input | 1 | Clock the seconds from an early divider stage |
| mode24_i | input | 1 | 1 = 24-hour counting, 0 = 12-hour counting |
| adj_i | input | 1 | Start the round-to-minute adjustment |
| wr_en_i | input | 1 | Write strobe for one digit |
| wr_sel_i | input | 4 | Digit written |
| wr_data_i | input | 4 | Write data |
| rd_sel_i | input | 4 | Digit read |
| rd_data_o | output | 4 | Selected digit, unimplemented bits 0 |
| busy_o | output | 1 | Deferred tick or adjustment pending |

## Verification
Some properties are checked every cycle:

- The divider clears under sub-second clear.
- Its upper stages stay frozen under stop.
- The time registers do not move while hold is asserted.
- busy_o rises after a deferred tick and after an adjust request.
- The seconds read zero once an adjustment is applied.

Other behaviour only shows up in the bench's scenarios. This covers the calendar arithmetic: month lengths, leap years, late correction of invalid dates, the 12-hour PM sequence, and the year and weekday wraps. It also covers exactly-once delivery of a deferred tick and the exact enable counts for stop, clear and test mode.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [3:0] y10;
    logic [3:0] y1;
    logic       mo10;
    logic [3:0] mo1;
    logic [1:0] d10;
    logic [3:0] d1;
    logic [2:0] wk;
    logic       pm;
    logic [1:0] h10;
    logic [3:0] h1;
    logic [2:0] mi10;
    logic [3:0] mi1;
    logic [2:0] s10;
    logic [3:0] s1;
  } rtc_time_t;

  function automatic logic [7:0] bcd2bin(input logic [3:0] t, input logic [3:0] u);
    return 8'(t) * 8'd10 + 8'(u);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] m, input logic leap);
    case (m)
      8'd2:                     return leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
      default:                  return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_BITS = 15,
  parameter int PRE_BITS = 2,
  parameter int TEST_TAP = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  input  logic stop_i,
  input  logic clr_sub_i,
  input  logic test_i,
  output logic tick_o
);
  localparam int UP_BITS = DIV_BITS - PRE_BITS;

  logic [PRE_BITS-1:0] pre_q;
  logic [UP_BITS-1:0]  up_q;
  logic [DIV_BITS-1:0] div;
  logic clr, run_up, pre_wrap;

  assign div      = {up_q, pre_q};
  assign clr      = clr_sub_i & ~test_i;
  assign run_up   = ~stop_i | test_i;
  assign pre_wrap = &pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      up_q  <= '0;
    end else if (clr) begin
      pre_q <= '0;
      up_q  <= '0;
    end else if (osc_en_i) begin
      pre_q <= pre_q + 1'b1;
      if (pre_wrap && run_up) up_q <= up_q + 1'b1;
    end
  end

  always_comb begin
    if (test_i) tick_o = osc_en_i & (&div[TEST_TAP-1:0]);
    else        tick_o = osc_en_i & pre_wrap & run_up & (&up_q) & ~clr;
  end

  a_r10_rest_clears_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_sub_i && !test_i |=> (pre_q == '0 && up_q == '0));

  a_r10_stop_holds_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !test_i && !clr_sub_i |=> $stable(up_q));

endmodule

// File: rtl/rtc_chain_next.sv
module rtc_chain_next
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  input  logic      mode24_i,
  input  logic      step_i,
  input  logic      adj_i,
  output rtc_time_t nxt_o
);
  logic c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0] hb, db, mb, yb, dim;

  always_comb begin
    nxt_o = cur_i;
    nxt_o.pm = cur_i.pm & ~mode24_i;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    hb  = bcd2bin({2'b0, cur_i.h10}, cur_i.h1);
    db  = bcd2bin({2'b0, cur_i.d10}, cur_i.d1);
    mb  = bcd2bin({3'b0, cur_i.mo10}, cur_i.mo1);
    yb  = bcd2bin(cur_i.y10, cur_i.y1);
    dim = month_days(mb, yb[1:0] == 2'd0);

    // seconds: adjust rounds to nearest minute, else one-second step
    if (adj_i) begin
      c_min = (cur_i.s10 >= 3'd3);
      nxt_o.s1 = 4'd0; nxt_o.s10 = 3'd0;
    end else if (step_i) begin
      if (cur_i.s1 >= 4'd9) begin
        nxt_o.s1 = 4'd0;
        if (cur_i.s10 >= 3'd5) begin nxt_o.s10 = 3'd0; c_min = 1'b1; end
        else nxt_o.s10 = cur_i.s10 + 3'd1;
      end else nxt_o.s1 = cur_i.s1 + 4'd1;
    end

    if (c_min) begin
      if (cur_i.mi1 >= 4'd9) begin
        nxt_o.mi1 = 4'd0;
        if (cur_i.mi10 >= 3'd5) begin nxt_o.mi10 = 3'd0; c_hr = 1'b1; end
        else nxt_o.mi10 = cur_i.mi10 + 3'd1;
      end else nxt_o.mi1 = cur_i.mi1 + 4'd1;
    end

    if (c_hr) begin
      if (mode24_i && hb >= 8'd23) begin
        nxt_o.h10 = 2'd0; nxt_o.h1 = 4'd0; c_day = 1'b1;
      end else if (!mode24_i && hb == 8'd11) begin
        nxt_o.h10 = 2'd1; nxt_o.h1 = 4'd2;
        nxt_o.pm  = ~cur_i.pm;
        c_day     = cur_i.pm;
      end else if (!mode24_i && hb >= 8'd12) begin
        nxt_o.h10 = 2'd0; nxt_o.h1 = 4'd1;
      end else if (cur_i.h1 >= 4'd9) begin
        nxt_o.h10 = cur_i.h10 + 2'd1; nxt_o.h1 = 4'd0;
      end else nxt_o.h1 = cur_i.h1 + 4'd1;
    end

    if (c_day) begin
      nxt_o.wk = (cur_i.wk >= 3'd6) ? 3'd0 : cur_i.wk + 3'd1;
      // invalid days roll forward here, not at write time
      if (db >= dim) begin
        nxt_o.d10 = 2'd0; nxt_o.d1 = 4'd1; c_mon = 1'b1;
      end else if (cur_i.d1 >= 4'd9) begin
        nxt_o.d10 = cur_i.d10 + 2'd1; nxt_o.d1 = 4'd0;
      end else nxt_o.d1 = cur_i.d1 + 4'd1;
    end

    if (c_mon) begin
      if (mb >= 8'd12) begin
        nxt_o.mo10 = 1'b0; nxt_o.mo1 = 4'd1; c_yr = 1'b1;
      end else if (cur_i.mo1 >= 4'd9) begin
        nxt_o.mo10 = 1'b1; nxt_o.mo1 = 4'd0;
      end else nxt_o.mo1 = cur_i.mo1 + 4'd1;
    end

    if (c_yr) begin
      if (yb >= 8'd99) begin
        nxt_o.y10 = 4'd0; nxt_o.y1 = 4'd0;
      end else if (cur_i.y1 >= 4'd9) begin
        nxt_o.y10 = cur_i.y10 + 4'd1; nxt_o.y1 = 4'd0;
      end else nxt_o.y1 = cur_i.y1 + 4'd1;
    end
  end

endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_pkg::*;
#(
  parameter int DIV_BITS = 15,
  parameter int PRE_BITS = 2,
  parameter int TEST_TAP = 3,
  parameter int ADJ_OSC  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_en_i,
  input  logic       hold_i,
  input  logic       stop_i,
  input  logic       clr_sub_i,
  input  logic       test_i,
  input  logic       mode24_i,
  input  logic       adj_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_sel_i,
  input  logic [3:0] wr_data_i,
  input  logic [3:0] rd_sel_i,
  output logic [3:0] rd_data_o,
  output logic       busy_o
);
  localparam int ADJ_W = $clog2(ADJ_OSC + 1);

  rtc_time_t        time_q, time_nxt, time_d;
  logic             tick, step, pend_q, adj_act_q, adj_apply;
  logic [ADJ_W-1:0] adj_cnt_q;

  rtc_prescaler #(
    .DIV_BITS(DIV_BITS), .PRE_BITS(PRE_BITS), .TEST_TAP(TEST_TAP)
  ) u_pre (
    .clk_i, .rst_ni, .osc_en_i, .stop_i, .clr_sub_i, .test_i, .tick_o(tick)
  );

  assign adj_apply = adj_act_q & osc_en_i & (adj_cnt_q == ADJ_W'(ADJ_OSC - 1));
  assign step      = (tick | pend_q) & ~hold_i & ~adj_apply;
  assign busy_o    = pend_q | adj_act_q;

  rtc_chain_next u_chain (
    .cur_i(time_q), .mode24_i, .step_i(step), .adj_i(adj_apply), .nxt_o(time_nxt)
  );

  // host write overrides the counted value of the addressed digit
  always_comb begin
    time_d = time_nxt;
    if (wr_en_i) begin
      case (wr_sel_i)
        4'd0:  time_d.y10  = wr_data_i;
        4'd1:  time_d.y1   = wr_data_i;
        4'd2:  time_d.mo10 = wr_data_i[0];
        4'd3:  time_d.mo1  = wr_data_i;
        4'd4:  time_d.d10  = wr_data_i[1:0];
        4'd5:  time_d.d1   = wr_data_i;
        4'd6:  time_d.wk   = wr_data_i[2:0];
        4'd7:  begin
          time_d.pm  = wr_data_i[2] & ~mode24_i;
          time_d.h10 = wr_data_i[1:0];
        end
        4'd8:  time_d.h1   = wr_data_i;
        4'd9:  time_d.mi10 = wr_data_i[2:0];
        4'd10: time_d.mi1  = wr_data_i;
        4'd11: time_d.s10  = wr_data_i[2:0];
        4'd12: time_d.s1   = wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel_i)
      4'd0:    rd_data_o = time_q.y10;
      4'd1:    rd_data_o = time_q.y1;
      4'd2:    rd_data_o = {3'b0, time_q.mo10};
      4'd3:    rd_data_o = time_q.mo1;
      4'd4:    rd_data_o = {2'b0, time_q.d10};
      4'd5:    rd_data_o = time_q.d1;
      4'd6:    rd_data_o = {1'b0, time_q.wk};
      4'd7:    rd_data_o = {1'b0, time_q.pm & ~mode24_i, time_q.h10};
      4'd8:    rd_data_o = time_q.h1;
      4'd9:    rd_data_o = {1'b0, time_q.mi10};
      4'd10:   rd_data_o = time_q.mi1;
      4'd11:   rd_data_o = {1'b0, time_q.s10};
      4'd12:   rd_data_o = time_q.s1;
      default: rd_data_o = 4'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q     <= '0;
      time_q.d1  <= 4'd1;
      time_q.mo1 <= 4'd1;
      pend_q     <= 1'b0;
      adj_act_q  <= 1'b0;
      adj_cnt_q  <= '0;
    end else begin
      time_q <= time_d;
      pend_q <= step ? 1'b0 : (pend_q | tick);
      if (adj_i && !adj_act_q) begin
        adj_act_q <= 1'b1;
        adj_cnt_q <= '0;
      end else if (adj_apply) begin
        adj_act_q <= 1'b0;
        adj_cnt_q <= '0;
      end else if (adj_act_q && osc_en_i) begin
        adj_cnt_q <= adj_cnt_q + 1'b1;
      end
    end
  end

  a_r8_hold_freezes_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && !wr_en_i && !adj_apply && !time_q.pm |=> $stable(time_q));

  a_r8_busy_while_deferred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && tick |=> busy_o);

  a_r9_busy_on_adjust: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_i |=> busy_o);

  a_r9_adjust_zeroes_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_apply && !wr_en_i |=> (time_q.s1 == 4'd0 && time_q.s10 == 3'd0));

endmodule

// File: tb/sim_rtc_bcd_clock.sv
module sim_rtc_bcd_clock;
  localparam int DIV_BITS = 8;
  localparam int TEST_TAP = 2;
  localparam int ADJ_OSC  = 4;
  localparam int SEC      = 1 << DIV_BITS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc = 0, hold = 0, stop = 0, clr = 0, test = 0, m24 = 1, adj = 0;
  logic wr_en = 0;
  logic [3:0] wr_sel = 0, wr_data = 0, rd_sel = 0;
  logic [3:0] rd_data;
  logic busy;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_bcd_clock #(.DIV_BITS(DIV_BITS), .PRE_BITS(2), .TEST_TAP(TEST_TAP), .ADJ_OSC(ADJ_OSC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc), .hold_i(hold), .stop_i(stop),
    .clr_sub_i(clr), .test_i(test), .mode24_i(m24), .adj_i(adj), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .busy_o(busy));

  // {mode24, start, expected}; nibbles y10 y1 mo10 mo1 d10 d1 wk h10 h1 mi10 mi1 s10 s1
  localparam logic [104:0] VEC [0:13] = '{
    {1'b1, 52'h9912316235959, 52'h0001010000000},  // R1 R6 R7 full wrap
    {1'b1, 52'h2402283235959, 52'h2402294000000},  // R4 leap Feb 28->29
    {1'b1, 52'h2302281235959, 52'h2303012000000},  // R4 non-leap Feb
    {1'b1, 52'h2402290235959, 52'h2403011000000},  // R4 leap Feb 29
    {1'b1, 52'h2302295235959, 52'h2303016000000},  // R5 invalid Feb 29
    {1'b1, 52'h2311312235959, 52'h2312013000000},  // R5 invalid Nov 31
    {1'b1, 52'h2304302235959, 52'h2305013000000},  // R4 30-day month
    {1'b1, 52'h2305153095959, 52'h2305153100000},  // R1 hour BCD carry
    {1'b0, 52'h2305153115959, 52'h2305153520000},  // R2 11AM -> 12PM
    {1'b0, 52'h2305153515959, 52'h2305164120000},  // R2 11PM -> 12AM next day
    {1'b0, 52'h2305153525959, 52'h2305153410000},  // R2 12PM -> 1PM
    {1'b0, 52'h2305153095959, 52'h2305153100000},  // R2 9 -> 10 in 12h
    {1'b1, 52'h2012316235959, 52'h2101010000000},  // R6 month wrap into year
    {1'b1, 52'h0002281235959, 52'h0002292000000}   // R4 year 00 is leap
  };

  task automatic chk(input string tag, input logic [51:0] got, input logic [51:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [3:0] d);
    @(negedge clk); wr_en = 1; wr_sel = 4'(sel); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int sel, output logic [3:0] d);
    rd_sel = 4'(sel); #1; d = rd_data;
  endtask

  task automatic load(input logic [51:0] v);
    for (int i = 0; i < 13; i++) wr(i, v[51-4*i -: 4]);
  endtask

  task automatic read_all(output logic [51:0] v);
    logic [3:0] d;
    for (int i = 0; i < 13; i++) begin rd(i, d); v[51-4*i -: 4] = d; end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc = 1;
      @(negedge clk); osc = 0;
    end
  endtask

  task automatic realign();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic sec_digits(output logic [51:0] v);
    logic [3:0] a, b;
    rd(11, a); rd(12, b); v = 52'({a, b});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [51:0] v;
    logic [3:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R13 reset state
    read_all(v); chk("R13 reset time", v, 52'h0001010000000);
    chk("R13 reset busy", 52'(busy), 52'd0);

    // vector table: one second per vector
    foreach (VEC[k]) begin
      m24 = VEC[k][104];
      load(VEC[k][103:52]);
      pulse(SEC);
      read_all(v);
      chk($sformatf("vector %0d calendar step", k), v, VEC[k][51:0]);
    end

    // R3 PM ignored in 24h
    m24 = 1; wr(7, 4'h6); rd(7, d); chk("R3 pm write ignored", 52'(d), 52'h2);
    // R12 unimplemented bits
    wr(11, 4'hF); rd(11, d); chk("R12 s10 mask", 52'(d), 52'h7);
    wr(2, 4'hF); rd(2, d); chk("R12 mo10 mask", 52'(d), 52'h1);
    wr(4, 4'hF); rd(4, d); chk("R12 d10 mask", 52'(d), 52'h3);
    m24 = 0; wr(7, 4'hF); rd(7, d); chk("R12 h10 mask 12h", 52'(d), 52'h7);
    m24 = 1;

    // R5 invalid date kept until carry
    load(52'h2302303120000); read_all(v);
    chk("R5 invalid date kept", v, 52'h2302303120000);

    // R8 hold defers one tick, applied once
    realign(); load(52'h2305153120000);
    @(negedge clk); hold = 1;
    pulse(SEC);
    rd(12, d); chk("R8 held seconds", 52'(d), 52'h0);
    chk("R8 busy while deferred", 52'(busy), 52'd1);
    hold = 0; @(negedge clk);
    rd(12, d); chk("R8 deferred tick applied", 52'(d), 52'h1);
    chk("R8 busy cleared", 52'(busy), 52'd0);
    pulse(SEC);
    rd(12, d); chk("R8 applied exactly once", 52'(d), 52'h2);

    // R9 adjust
    realign(); load(52'h2305153121029);
    @(negedge clk); adj = 1; @(negedge clk); adj = 0;
    chk("R9 busy during adjust", 52'(busy), 52'd1);
    pulse(ADJ_OSC - 1); sec_digits(v); chk("R9 unchanged before window end", v, 52'h29);
    pulse(1); read_all(v); chk("R9 29 rounds down", v, 52'h2305153121000);
    chk("R9 busy after adjust", 52'(busy), 52'd0);
    realign(); load(52'h2305153121030);
    @(negedge clk); adj = 1; @(negedge clk); adj = 0;
    pulse(ADJ_OSC); read_all(v); chk("R9 30 rounds up", v, 52'h2305153121100);
    realign(); load(52'h2305153125959);
    @(negedge clk); adj = 1; @(negedge clk); adj = 0;
    pulse(ADJ_OSC); read_all(v); chk("R9 59 carries to hour", v, 52'h2305153130000);

    // R10 stop and sub-second clear
    realign(); load(52'h2305153120000);
    @(negedge clk); stop = 1;
    pulse(SEC); rd(12, d); chk("R10 stop blocks tick", 52'(d), 52'h0);
    stop = 0;
    pulse(SEC); rd(12, d); chk("R10 counting resumes", 52'(d), 52'h1);
    pulse(200);
    @(negedge clk); clr = 1; pulse(10); clr = 0;
    pulse(SEC - 1); rd(12, d); chk("R10 clear restarts divider", 52'(d), 52'h1);
    pulse(1); rd(12, d); chk("R10 full second after clear", 52'(d), 52'h2);

    // R11 test mode fast tick, stop/clear ignored
    realign(); load(52'h2305153120000);
    @(negedge clk); test = 1; stop = 1; clr = 1;
    pulse(1 << TEST_TAP); rd(12, d); chk("R11 fast tick", 52'(d), 52'h1);
    pulse(1 << TEST_TAP); rd(12, d); chk("R11 second fast tick", 52'(d), 52'h2);
    @(negedge clk); test = 0; stop = 0; clr = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule